// File: doc/BRIEF.md
# Clock Loss Frequency Monitor

This block watches a slow, asynchronous clock from a fast, trusted reference clock. It flags a fault when the watched clock stops or runs too slowly. The block counts rising edges of the watched clock over a fixed window of reference cycles. A window that ends with fewer edges than a set threshold raises the error. While the error is up, the block drives the active-low fault pin, which it shares with the watchdog. When a later window passes, the error clears. The pin stays driven for a fixed release delay after that, and is then let go.

The monitor comes out of reset enabled. The first service write of the watchdog carries a select bit that keeps the monitor on or turns it off. That choice is made once: later writes do not change it until the next reset. In a real system the window and the threshold are set so that an instruction clock of 10 kHz or more never fails a window, and one below 10 Hz always fails.

Top module: `clkloss_monitor`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `mon_err`, `mon_pin_oe` and `fault_pin_oe` are 0 (with `wd_pin_oe` low).
- R2: After reset the monitor is enabled. If the watched clock never toggles, `mon_err` rises two reference cycles after the first window of `REF_WIN_CYC` cycles ends.
- R3: A window is `REF_WIN_CYC` reference cycles long. A window with at least `MIN_EDGES` counted rising edges passes and raises no error. This includes a window with exactly `MIN_EDGES` edges.
- R4: A window with fewer than `MIN_EDGES` counted edges sets `mon_err` and `mon_pin_oe` one cycle after the window's verdict is registered.
- R5: Once set, the error stays set across every later failing window. It stays set in the cycles between windows.
- R6: After a passing window clears the error, `mon_pin_oe` stays 1 for exactly `RELEASE_CYC` more cycles (default 24, within 16..32) and then goes to 0.
- R7: The watched clock passes through a two-flop synchronizer and a rising-edge detector. Each 0-to-1 transition counts once. A clock held high counts as one edge in total.
- R8: The first `svc_wr` pulse after reset latches `svc_mon_sel`. A value of 0 disables the monitor. One cycle after the monitor is disabled, `mon_err` and `mon_pin_oe` are 0, and they stay 0 whatever the watched clock does.
- R9: Every `svc_wr` pulse after the first is ignored. A later 1 does not re-enable a disabled monitor, and a later 0 does not disable an enabled one.
- R10: `fault_pin_oe` is 1 whenever `wd_pin_oe` or `mon_pin_oe` is 1. A value of 1 means the shared pin is pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_clk | input | 1 | Watched clock, asynchronous to clk |
| svc_wr | input | 1 | One-cycle pulse for a valid watchdog service write |
| svc_mon_sel | input | 1 | Monitor select bit carried by the service write (1 = on) |
| wd_pin_oe | input | 1 | Watchdog's pull-low request for the shared pin |
| mon_err | output | 1 | Frequency error flag |
| mon_pin_oe | output | 1 | Monitor's pull-low request (error or release delay) |
| fault_pin_oe | output | 1 | Combined pull-low enable for the shared fault pin |

## Verification
The watched clock is driven with a range of half-periods: a fast clock that gives many edges per window, one that gives exactly the threshold, one that gives sometimes and always fewer, a clock stuck low, and a clock stuck high. Together these separate a threshold comparison that is off by one from a correct one. They also show whether a level is mistaken for an edge. Switching between passing and failing stretches exercises the error hold, and measures the release delay cycle by cycle. Two reset sequences exercise the one-time select: one disables the monitor and then tries to re-enable it, the other keeps it on and then tries to disable it. The watchdog request is toggled on its own to check the shared pin.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

    // Verdict handed from the window counter to the error/hold stage
    typedef struct packed {
        logic done;   // one-cycle pulse: a window just closed
        logic pass;   // valid with done: edge count met the threshold
    } clkmon_verdict_t;

    // One-time enable latch state at the top level
    typedef struct packed {
        logic en;
        logic locked;
    } clkmon_cfg_t;

endpackage

// File: rtl/clkmon_sync.sv
module clkmon_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    typedef struct packed {
        logic m1;    // first synchronizer flop
        logic m2;    // second synchronizer flop
        logic last;  // previous synchronized level
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.m1   = async_in;
        st_d.m2   = st_q.m1;
        st_d.last = st_q.m2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.m2 & ~st_q.last;

    // R7
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/clkmon_window.sv
module clkmon_window
    import clkmon_pkg::*;
#(
    parameter int REF_WIN_CYC = 64,
    parameter int MIN_EDGES   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            rise,
    output clkmon_verdict_t verdict
);
    localparam int WW = (REF_WIN_CYC > 1) ? $clog2(REF_WIN_CYC) : 1;
    localparam int EW = $clog2(MIN_EDGES + 1);
    localparam logic [WW-1:0] WIN_LAST = WW'(REF_WIN_CYC - 1);
    localparam logic [EW-1:0] EDGE_MAX = EW'(MIN_EDGES);

    typedef struct packed {
        logic [WW-1:0]   win;
        logic [EW-1:0]   edges;
        clkmon_verdict_t vrd;
    } win_t;

    win_t st_d, st_q;
    logic [EW-1:0] edges_nxt;
    logic          win_end;

    always_comb begin
        // saturating edge count including this cycle's edge
        if (rise && st_q.edges != EDGE_MAX) edges_nxt = st_q.edges + EW'(1);
        else                                edges_nxt = st_q.edges;
        win_end = (st_q.win == WIN_LAST);

        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            st_d.vrd.done = win_end;
            st_d.vrd.pass = win_end && (edges_nxt >= EDGE_MAX);
            if (win_end) begin
                st_d.win   = '0;
                st_d.edges = '0;
            end else begin
                st_d.win   = st_q.win + WW'(1);
                st_d.edges = edges_nxt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign verdict = st_q.vrd;

    // R3
    window_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        verdict.done |=> !verdict.done);

    // R3
    pass_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        verdict.pass |-> verdict.done);

endmodule

// File: rtl/clkmon_hold.sv
module clkmon_hold
    import clkmon_pkg::*;
#(
    parameter int RELEASE_CYC = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  clkmon_verdict_t vin,
    output logic            err,
    output logic            pin_oe
);
    localparam int RW = $clog2(RELEASE_CYC + 1);
    localparam logic [RW-1:0] REL_LOAD = RW'(RELEASE_CYC);

    typedef struct packed {
        logic          err;
        logic [RW-1:0] rel;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (vin.done && !vin.pass) begin
            st_d.err = 1'b1;
            st_d.rel = '0;
        end else if (vin.done && vin.pass && st_q.err) begin
            st_d.err = 1'b0;
            st_d.rel = REL_LOAD;
        end else if (st_q.rel != '0) begin
            st_d.rel = st_q.rel - RW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err    = st_q.err;
    assign pin_oe = st_q.err | (st_q.rel != '0);

    // R4
    fail_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vin.done && !vin.pass && !clr) |=> err);

    // R5
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clr && !(vin.done && vin.pass)) |=> err);

    // R6
    release_load_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        $fell(err) |-> pin_oe);

endmodule

// File: rtl/clkloss_monitor.sv
module clkloss_monitor
    import clkmon_pkg::*;
#(
    parameter int REF_WIN_CYC = 64,
    parameter int MIN_EDGES   = 4,
    parameter int RELEASE_CYC = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mon_clk,
    input  logic svc_wr,
    input  logic svc_mon_sel,
    input  logic wd_pin_oe,
    output logic mon_err,
    output logic mon_pin_oe,
    output logic fault_pin_oe
);
    clkmon_cfg_t     cfg_d, cfg_q;
    clkmon_verdict_t verdict;
    logic            rise;
    logic            clr;

    always_comb begin
        cfg_d = cfg_q;
        if (svc_wr && !cfg_q.locked) begin
            cfg_d.en     = svc_mon_sel;
            cfg_d.locked = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '{en: 1'b1, locked: 1'b0};
        else        cfg_q <= cfg_d;
    end

    assign clr = ~cfg_q.en;

    clkmon_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (mon_clk),
        .rise     (rise)
    );

    clkmon_window #(
        .REF_WIN_CYC (REF_WIN_CYC),
        .MIN_EDGES   (MIN_EDGES)
    ) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .rise    (rise),
        .verdict (verdict)
    );

    clkmon_hold #(
        .RELEASE_CYC (RELEASE_CYC)
    ) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .vin    (verdict),
        .err    (mon_err),
        .pin_oe (mon_pin_oe)
    );

    assign fault_pin_oe = mon_pin_oe | wd_pin_oe;

    // R9
    lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.locked |=> (cfg_q.locked && $stable(cfg_q.en)));

    // R8
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.en |=> (!mon_err && !mon_pin_oe));

    // R10
    shared_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_err && !wd_pin_oe) |-> fault_pin_oe);

endmodule

// File: tb/clkloss_monitor_tb.sv
module clkloss_monitor_tb;
    localparam int W   = 64;
    localparam int MIN = 4;
    localparam int REL = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mon_clk = 1'b0;
    logic svc_wr = 1'b0;
    logic svc_mon_sel = 1'b0;
    logic wd_pin_oe = 1'b0;
    logic mon_err, mon_pin_oe, fault_pin_oe;

    always #2 clk = ~clk;   // 250 MHz

    clkloss_monitor #(.REF_WIN_CYC(W), .MIN_EDGES(MIN), .RELEASE_CYC(REL)) u_dut (
        .clk(clk), .rst_n(rst_n), .mon_clk(mon_clk), .svc_wr(svc_wr),
        .svc_mon_sel(svc_mon_sel), .wd_pin_oe(wd_pin_oe),
        .mon_err(mon_err), .mon_pin_oe(mon_pin_oe), .fault_pin_oe(fault_pin_oe)
    );

    int    vectors = 0;
    int    fails = 0;
    string tag = "R1";

    // watched-clock generator: half period in reference cycles, 0 = hold level
    int   half = 0;
    int   ph = 0;
    logic hold_lvl = 1'b0;
    always @(negedge clk) begin
        if (half == 0) begin
            mon_clk <= hold_lvl;
            ph = 0;
        end else if (ph >= half - 1) begin
            ph = 0;
            mon_clk <= ~mon_clk;
        end else begin
            ph++;
        end
    end

    // behavioural reference model
    logic hist[$];
    bit   m_en, m_locked, m_done, m_pass, m_err;
    int   m_win, m_edges, m_rel;

    task automatic model_reset();
        hist = '{1'b0, 1'b0, 1'b0};
        m_en = 1; m_locked = 0; m_done = 0; m_pass = 0; m_err = 0;
        m_win = 0; m_edges = 0; m_rel = 0;
    endtask

    task automatic model_step();
        bit rise, nd, np;
        int n;
        rise = hist[1] && !hist[2];   // samples from two and three edges back
        if (!m_en) begin
            m_win = 0; m_edges = 0; m_done = 0; m_pass = 0; m_err = 0; m_rel = 0;
        end else begin
            n  = (m_edges + (rise ? 1 : 0) > MIN) ? MIN : m_edges + (rise ? 1 : 0);
            nd = (m_win == W - 1);
            np = nd && (n >= MIN);
            if (m_done && !m_pass) begin
                m_err = 1; m_rel = 0;
            end else if (m_done && m_pass && m_err) begin
                m_err = 0; m_rel = REL;
            end else if (m_rel > 0) begin
                m_rel--;
            end
            m_done  = nd;
            m_pass  = np;
            m_win   = nd ? 0 : m_win + 1;
            m_edges = nd ? 0 : n;
        end
        if (svc_wr && !m_locked) begin
            m_en = svc_mon_sel;
            m_locked = 1;
        end
        hist.push_front(mon_clk);
        void'(hist.pop_back());
    endtask

    initial model_reset();

    always @(posedge clk) begin
        bit e_err, e_oe, e_pin;
        if (!rst_n) model_reset();
        else        model_step();
        e_err = m_err;
        e_oe  = m_err || (m_rel > 0);
        e_pin = e_oe || wd_pin_oe;
        #1;
        vectors++;
        if (mon_err !== e_err || mon_pin_oe !== e_oe || fault_pin_oe !== e_pin) begin
            fails++;
            $display("FAIL %s t=%0t err/oe/pin actual=%b%b%b expected=%b%b%b",
                     tag, $time, mon_err, mon_pin_oe, fault_pin_oe, e_err, e_oe, e_pin);
        end
    end

    task automatic run(input int cycles);
        repeat (cycles) @(negedge clk);
    endtask

    task automatic service(input logic sel);
        @(negedge clk);
        svc_wr = 1'b1; svc_mon_sel = sel;
        @(negedge clk);
        svc_wr = 1'b0; svc_mon_sel = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        run(4);
        rst_n = 1'b1;
    endtask

    bit finished = 0;

    initial begin
        // R1: reset state
        tag = "R1"; half = 0; hold_lvl = 0;
        run(5);
        rst_n = 1'b1;
        run(2);
        // R2: clock absent from reset
        tag = "R2"; run(200);
        // R3 R6: fast clock clears the error, release delay measured
        tag = "R6"; half = 2; run(200);
        // R4 R5: slow clock, one to two edges per window
        tag = "R5"; half = 20; run(300);
        // R3: exactly the threshold (period 16 -> 4 edges per 64)
        tag = "R3"; half = 8; run(300);
        // R4: period 18, 3 or 4 edges per window
        tag = "R4"; half = 9; run(400);
        // R4: period 22, always fewer than threshold
        tag = "R4"; half = 11; run(300);
        // R7: clock stuck high counts a single edge
        tag = "R3"; half = 2; run(150);
        tag = "R7"; half = 0; hold_lvl = 1; run(300);
        // R10: watchdog request alone
        tag = "R10"; half = 2; run(150);
        wd_pin_oe = 1; run(10); wd_pin_oe = 0; run(10);
        // R8 R9: disable while in error, then a later write cannot re-enable
        tag = "R8"; half = 0; hold_lvl = 0; run(150);
        service(1'b0); run(200);
        tag = "R9"; service(1'b1); run(200);
        // R9: keep enabled, a later disable is ignored
        do_reset();
        tag = "R9"; service(1'b1); service(1'b0); run(300);
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule